// File: doc/BRIEF.md
# Exception and Interrupt Control Coprocessor

This block is the system-control register unit of a small 32-bit pipelined processor. Each cycle it looks at the instruction in the execute stage and at six external interrupt lines. It decides whether to take an exception and, if so, which cause code to report. When an exception is taken it records the return address, the faulting memory address and the cause. It also saves the privilege and interrupt-enable state on a three-deep stack of mode/enable pairs.

Software reaches four registers through a move-to/move-from port indexed by register number. Register 8 is the faulting address, 12 is status, 13 is cause and 14 is the return address. A privileged return strobe pops the mode stack. The pipeline uses `take_exc` and `exc_code` to flush and redirect fetch; that redirection lies outside this block. The `user_mode` and `irq_en` outputs report the current pair of the stack.

Top module: `exc_ctrl_unit`

## Requirements
- R1: Reading index 8, 12, 13 or 14 returns the fault-address, status, cause and return-address registers. Any other index reads 0. After reset all four registers read 0, so `user_mode` and `irq_en` are 0.
- R2: A write to status (index 12) stores only bits 15..10 and 5..0; all other bits read 0. A write is dropped in a cycle that takes an exception.
- R3: Status bits 5..0 are three pairs: old in 5..4, previous in 3..2, current in 1..0. In each pair the upper bit is the mode (1 = user) and the lower bit is the enable (1 = enabled). Taking an exception shifts the pairs up by one and loads the current pair with 00. Status bits 15..10 keep their value.
- R4: `ret_exc` in kernel mode copies the previous pair into the current pair and leaves the old and previous pairs unchanged. In user mode it has no effect.
- R5: Interrupt line n (status bit 10+n is its mask) is taken with code 0 only when status bit 0, the mask bit and the line are all 1.
- R6: Cause bits 15..10 always show the live `irq_lines`. Cause bits 5..2 (code) and bit 31 (delay slot) change only when an exception is taken. Software writes to cause have no effect.
- R7: On a taken exception the return-address register gets `ex_pc`, or `ex_pc`-4 when `ex_in_slot` is 1.
- R8: With `ovf_check` high, an overflow exception (code 12) is raised when `sign_a` equals `sign_b` and `sign_res` differs from them. With `ovf_check` low, no overflow exception is raised.
- R9: A data access (`mem_rd` or `mem_wr`) faults when it is misaligned, or when it is protected and the current mode is user. The code is 4 for a load and 5 for a store, and `mem_addr` goes into the fault-address register. A protected access in kernel mode does not fault.
- R10: `fetch_bad` raises code 4 and loads `ex_pc` into the fault-address register. `sys_call` always raises code 8.
- R11: Priority is fetch fault, then syscall, then overflow, then data fault, then interrupt. Any synchronous exception beats a pending interrupt.
- R12: `take_exc` and `exc_code` are combinational in the cycle of the request. `user_mode` and `irq_en` follow status bits 1 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_sel | input | 5 | Register index for read and write |
| csr_we | input | 1 | Move-to write strobe |
| csr_wdata | input | 32 | Move-to write data |
| csr_rdata | output | 32 | Move-from read data |
| ex_pc | input | 32 | Address of the execute-stage instruction |
| ex_in_slot | input | 1 | Execute-stage instruction is in a branch delay slot |
| fetch_bad | input | 1 | Instruction address is invalid |
| sys_call | input | 1 | Syscall instruction in execute |
| ovf_check | input | 1 | Signed add/subtract that may trap on overflow |
| sign_a | input | 1 | Sign of the first operand |
| sign_b | input | 1 | Sign of the second operand, after negation for subtract |
| sign_res | input | 1 | Sign of the result |
| mem_rd | input | 1 | Load in execute |
| mem_wr | input | 1 | Store in execute |
| mem_misalign | input | 1 | Data address is misaligned |
| mem_prot | input | 1 | Data address is kernel-protected |
| mem_addr | input | 32 | Data address |
| ret_exc | input | 1 | Return-from-exception strobe |
| irq_lines | input | 6 | External interrupt lines |
| take_exc | output | 1 | Take an exception this cycle |
| exc_code | output | 4 | Cause code of the exception taken |
| user_mode | output | 1 | Current mode is user |
| irq_en | output | 1 | Current global interrupt enable |

## Verification
The assertions assume that `mem_rd` and `mem_wr` are never high together, and that `ex_pc` is word-aligned whenever `ex_in_slot` is high, so that the previous instruction's address is `ex_pc`-4. The stimulus drives at most one memory direction per cycle and uses only word-aligned program counters with the delay-slot flag. The rule against taking an interrupt while disabled is checked only in cycles with no synchronous request, because the bench raises interrupt lines alongside overflow requests on purpose to exercise priority.

// File: rtl/exc_ctrl_unit.sv
module exc_ctrl_unit #(
  parameter int XLEN = 32,
  parameter int NIRQ = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [4:0]      csr_sel,
  input  logic            csr_we,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  input  logic [XLEN-1:0] ex_pc,
  input  logic            ex_in_slot,
  input  logic            fetch_bad,
  input  logic            sys_call,
  input  logic            ovf_check,
  input  logic            sign_a,
  input  logic            sign_b,
  input  logic            sign_res,
  input  logic            mem_rd,
  input  logic            mem_wr,
  input  logic            mem_misalign,
  input  logic            mem_prot,
  input  logic [XLEN-1:0] mem_addr,
  input  logic            ret_exc,
  input  logic [NIRQ-1:0] irq_lines,
  output logic            take_exc,
  output logic [3:0]      exc_code,
  output logic            user_mode,
  output logic            irq_en
);
  localparam logic [4:0] SEL_BADA = 5'd8;
  localparam logic [4:0] SEL_STAT = 5'd12;
  localparam logic [4:0] SEL_CAUS = 5'd13;
  localparam logic [4:0] SEL_RETA = 5'd14;
  localparam int MLO = 10;
  localparam int MHI = MLO + NIRQ - 1;

  logic [XLEN-1:0] bad_addr, ret_addr;
  logic [NIRQ-1:0] irq_mask;
  logic [5:0]      mstack;
  logic [3:0]      cause_code;
  logic            cause_slot;

  logic ovf_hit, dat_hit, irq_hit, sync_hit;

  assign user_mode = mstack[1];
  assign irq_en    = mstack[0];

  assign ovf_hit  = ovf_check && (sign_a == sign_b) && (sign_res != sign_a);
  assign dat_hit  = (mem_rd || mem_wr) && (mem_misalign || (mem_prot && user_mode));
  assign irq_hit  = irq_en && |(irq_lines & irq_mask);
  assign sync_hit = fetch_bad || sys_call || ovf_hit || dat_hit;
  assign take_exc = sync_hit || irq_hit;

  always_comb begin
    if (fetch_bad)    exc_code = 4'd4;
    else if (sys_call) exc_code = 4'd8;
    else if (ovf_hit)  exc_code = 4'd12;
    else if (dat_hit)  exc_code = mem_wr ? 4'd5 : 4'd4;
    else               exc_code = 4'd0;
  end

  always_comb begin
    csr_rdata = '0;
    case (csr_sel)
      SEL_BADA: csr_rdata = bad_addr;
      SEL_STAT: begin
        csr_rdata[MHI:MLO] = irq_mask;
        csr_rdata[5:0]     = mstack;
      end
      SEL_CAUS: begin
        csr_rdata[XLEN-1]  = cause_slot;
        csr_rdata[MHI:MLO] = irq_lines;
        csr_rdata[5:2]     = cause_code;
      end
      SEL_RETA: csr_rdata = ret_addr;
      default:  csr_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bad_addr   <= '0;
      ret_addr   <= '0;
      irq_mask   <= '0;
      mstack     <= '0;
      cause_code <= '0;
      cause_slot <= 1'b0;
    end else if (take_exc) begin
      mstack     <= {mstack[3:0], 2'b00};
      cause_code <= exc_code;
      cause_slot <= ex_in_slot;
      ret_addr   <= ex_in_slot ? ex_pc - XLEN'(4) : ex_pc;
      if (fetch_bad)
        bad_addr <= ex_pc;
      else if (dat_hit && !sys_call && !ovf_hit)
        bad_addr <= mem_addr;
    end else if (ret_exc && !user_mode) begin
      mstack[1:0] <= mstack[3:2];
    end else if (csr_we) begin
      case (csr_sel)
        SEL_STAT: begin
          irq_mask <= csr_wdata[MHI:MLO];
          mstack   <= csr_wdata[5:0];
        end
        SEL_RETA: ret_addr <= csr_wdata;
        default: ;
      endcase
    end
  end

  assert_push_on_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |=> (mstack == {$past(mstack[3:0]), 2'b00}) && (irq_mask == $past(irq_mask)));

  assert_rfe_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_exc && !take_exc && !user_mode) |=>
      (mstack[1:0] == $past(mstack[3:2])) && (mstack[5:2] == $past(mstack[5:2])));

  assert_rfe_user_noeffect_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_exc && !take_exc && user_mode) |=> $stable(mstack));

  assert_no_irq_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en && !fetch_bad && !sys_call && !ovf_check && !mem_rd && !mem_wr) |-> !take_exc);

  assert_ret_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |=> ret_addr == ($past(ex_in_slot) ? $past(ex_pc) - XLEN'(4) : $past(ex_pc)));

  assert_cause_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !take_exc |=> $stable(cause_code) && $stable(cause_slot));

  assert_kernel_after_take_R12: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |=> !user_mode && !irq_en);

  assert_sync_beats_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_call || fetch_bad) |-> (take_exc && exc_code != 4'd0));
endmodule

// File: tb/exc_ctrl_unit_tb_top.sv
module exc_ctrl_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  csr_sel;
  logic        csr_we;
  logic [31:0] csr_wdata, csr_rdata, ex_pc, mem_addr;
  logic        ex_in_slot, fetch_bad, sys_call, ovf_check, sign_a, sign_b, sign_res;
  logic        mem_rd, mem_wr, mem_misalign, mem_prot, ret_exc;
  logic [5:0]  irq_lines;
  logic        take_exc, user_mode, irq_en;
  logic [3:0]  exc_code;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int    q_what[$];
  logic [31:0] q_exp[$];
  string q_tag[$];

  always #5 clk = ~clk;

  exc_ctrl_unit dut_i (
    .clk(clk), .rst_n(rst_n), .csr_sel(csr_sel), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .ex_pc(ex_pc),
    .ex_in_slot(ex_in_slot), .fetch_bad(fetch_bad), .sys_call(sys_call),
    .ovf_check(ovf_check), .sign_a(sign_a), .sign_b(sign_b), .sign_res(sign_res),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_misalign(mem_misalign),
    .mem_prot(mem_prot), .mem_addr(mem_addr), .ret_exc(ret_exc),
    .irq_lines(irq_lines), .take_exc(take_exc), .exc_code(exc_code),
    .user_mode(user_mode), .irq_en(irq_en)
  );

  // what: 0 rdata, 1 take_exc, 2 exc_code, 3 user_mode, 4 irq_en
  task automatic expect_out(input int what, input logic [31:0] val, input string tag);
    q_what.push_back(what);
    q_exp.push_back(val);
    q_tag.push_back(tag);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    csr_sel = 5'd0; csr_we = 0; csr_wdata = '0; ex_pc = 32'h0; ex_in_slot = 0;
    fetch_bad = 0; sys_call = 0; ovf_check = 0; sign_a = 0; sign_b = 0; sign_res = 0;
    mem_rd = 0; mem_wr = 0; mem_misalign = 0; mem_prot = 0; mem_addr = '0;
    ret_exc = 0; irq_lines = '0;
  endtask

  task automatic rd(input logic [4:0] sel, input logic [31:0] val, input string tag);
    step();
    csr_sel = sel;
    expect_out(0, val, tag);
  endtask

  always @(negedge clk) begin
    while (q_what.size() > 0) begin
      int w;
      logic [31:0] e, a;
      string t;
      w = q_what.pop_front();
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      case (w)
        0: a = csr_rdata;
        1: a = {31'd0, take_exc};
        2: a = {28'd0, exc_code};
        3: a = {31'd0, user_mode};
        default: a = {31'd0, irq_en};
      endcase
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", t, w, a, e);
      end
    end
  end

  initial begin
    step();
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 R12 reset state
    rd(5'd12, 32'h0, "R1 status reset");
    expect_out(3, 0, "R12 user after reset");
    expect_out(4, 0, "R12 ien after reset");
    expect_out(1, 0, "R12 no take after reset");
    rd(5'd13, 32'h0, "R1 cause reset");
    rd(5'd14, 32'h0, "R1 retaddr reset");
    rd(5'd8, 32'h0, "R1 badaddr reset");
    rd(5'd3, 32'h0, "R1 unmapped index");
    // R2 write mask
    step(); csr_we = 1; csr_sel = 5'd12; csr_wdata = 32'hFFFF_040F;
    rd(5'd12, 32'h0000_040F, "R2 status write mask");
    expect_out(3, 1, "R12 user mode");
    expect_out(4, 1, "R12 irq enable");
    // R10 syscall
    step(); sys_call = 1; ex_pc = 32'h100;
    expect_out(1, 1, "R10 syscall take");
    expect_out(2, 8, "R10 syscall code");
    rd(5'd12, 32'h0000_043C, "R3 push on syscall");
    expect_out(3, 0, "R3 kernel after take");
    expect_out(4, 0, "R3 disabled after take");
    rd(5'd13, 32'h0000_0020, "R6 cause code 8");
    rd(5'd14, 32'h0000_0100, "R7 return addr");
    // R4 return in kernel
    step(); ret_exc = 1;
    rd(5'd12, 32'h0000_043F, "R4 pop keeps old");
    // R5 masked line
    step(); irq_lines = 6'b000010; csr_sel = 5'd13;
    expect_out(0, 32'h0000_0820, "R6 live pending bits");
    expect_out(1, 0, "R5 masked line ignored");
    // R5 enabled line, delay slot
    step(); irq_lines = 6'b000001; ex_pc = 32'h200; ex_in_slot = 1;
    expect_out(1, 1, "R5 interrupt taken");
    expect_out(2, 0, "R5 interrupt code");
    step(); irq_lines = 6'b000001; csr_sel = 5'd14;
    expect_out(0, 32'h0000_01FC, "R7 slot return addr");
    expect_out(1, 0, "R5 disabled no retake");
    step(); irq_lines = 6'b000001; csr_sel = 5'd13;
    expect_out(0, 32'h8000_0400, "R6 slot bit and pending");
    rd(5'd12, 32'h0000_043C, "R3 push on interrupt");
    // R9 protected in kernel
    step(); mem_rd = 1; mem_prot = 1; mem_addr = 32'h2000;
    expect_out(1, 0, "R9 kernel protected ok");
    step(); mem_rd = 1; mem_misalign = 1; mem_addr = 32'h1003; ex_pc = 32'h300;
    expect_out(1, 1, "R9 misaligned load take");
    expect_out(2, 4, "R9 load code");
    rd(5'd8, 32'h0000_1003, "R9 bad addr load");
    rd(5'd13, 32'h0000_0010, "R6 cause code 4");
    rd(5'd12, 32'h0000_0430, "R3 second push");
    // R8 no overflow cases
    step(); sign_a = 0; sign_b = 0; sign_res = 1;
    expect_out(1, 0, "R8 unsigned no trap");
    step(); ovf_check = 1; sign_a = 1; sign_b = 0; sign_res = 0;
    expect_out(1, 0, "R8 mixed signs no trap");
    // R11 overflow beats interrupt
    step(); csr_we = 1; csr_sel = 5'd12; csr_wdata = 32'h0000_0401;
    step(); irq_lines = 6'b000001; ovf_check = 1; sign_res = 1; ex_pc = 32'h400;
    expect_out(1, 1, "R8 overflow take");
    expect_out(2, 12, "R11 overflow beats irq");
    rd(5'd12, 32'h0000_0404, "R3 push from enabled kernel");
    rd(5'd13, 32'h0000_0030, "R6 cause code 12");
    // R11 syscall beats overflow
    step(); sys_call = 1; ovf_check = 1; sign_res = 1;
    expect_out(2, 8, "R11 syscall beats overflow");
    // R4 return in user ignored
    step(); csr_we = 1; csr_sel = 5'd12; csr_wdata = 32'h0000_0002;
    step(); ret_exc = 1;
    rd(5'd12, 32'h0000_0002, "R4 return ignored in user");
    // R9 protected store in user
    step(); mem_wr = 1; mem_prot = 1; mem_addr = 32'h3000; ex_pc = 32'h500;
    expect_out(2, 5, "R9 store code");
    rd(5'd8, 32'h0000_3000, "R9 bad addr store");
    rd(5'd13, 32'h0000_0014, "R6 cause code 5");
    // R10 fetch fault
    step(); fetch_bad = 1; ex_pc = 32'h6002; mem_rd = 1; mem_misalign = 1; mem_addr = 32'h7777;
    expect_out(2, 4, "R10 fetch code");
    rd(5'd8, 32'h0000_6002, "R10 bad addr is pc");
    rd(5'd14, 32'h0000_6002, "R7 return addr fetch");
    // R6 cause not writable
    step(); csr_we = 1; csr_sel = 5'd13; csr_wdata = 32'hFFFF_FFFF;
    rd(5'd13, 32'h0000_0010, "R6 cause write ignored");
    // R2 write dropped on take
    step(); csr_we = 1; csr_sel = 5'd12; csr_wdata = 32'h0000_FC3F; sys_call = 1;
    rd(5'd12, 32'h0000_0000, "R2 write dropped on take");
    step();
    step();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule